// File: doc/BRIEF.md
# Two-Step Flash Converter Digital Back End

This block is the digital half of a 10-bit two-step flash converter. On every rising clock edge it takes the two thermometer words that the comparator banks produce. The coarse word has 15 outputs and fixes the top four bits. The fine word has 67 outputs and resolves the low six bits inside the chosen ladder segment, with two extra thresholds on each side of that segment. The block merges the two words into one corrected binary code. It saturates the result at both ends of the range and raises a separate overflow flag. The result then goes through a fixed two-register output pipeline.

Two more functions sit beside the encoder. A two-bit channel select for the analog multiplexer is stored through an active-low write strobe. The select that is in force during a sample window travels down the pipeline with that sample's code. A power-down input freezes every output. When power-down is released, the first two fresh samples are marked as not valid, because the comparators need time to settle again.

Top module: `tsf_adc_backend`

## Requirements
- R1: The code is `(ones in coarse word) * 64 + (ones in fine word) - 2`. A coarse decision that is one segment off is corrected as long as the fine count stays inside 0..67.
- R2: A non-monotonic thermometer word is weighted by its count of ones. A swapped adjacent pair (bit n-1 cleared, bit n set) gives the same code as the clean word.
- R3: When the corrected sum is below zero, `code_o` is 0 and `ovf_o` is 0.
- R4: When the corrected sum is 1024 or more, `code_o` is 1023 (all ones) and `ovf_o` is 1. `ovf_o` is 0 for any sum of 1023 or less.
- R5: The words present at rising edge k appear on the outputs just after rising edge k+1, provided power-down is low at both edges.
- R6: On a rising edge with `wr_n` low, the channel select loads `chan_addr_i` (0..3 select inputs 1..4). While `wr_n` is high the select keeps its value. Writes are accepted during power-down.
- R7: `chan_o` reports the select that was in force before the edge that captured the sample. A write on that same edge applies only to the next sample.
- R8: On a rising edge with `pwr_dn_i` high, `code_o`, `ovf_o`, `chan_o` and `data_valid_o` all keep their values.
- R9: The two samples captured on the first two rising edges after reset or after power-down is released carry `data_valid_o` = 0. Later samples carry 1.
- R10: While `rst_n` is low, `code_o`, `ovf_o`, `chan_o` and `data_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; rising edge ends the sample window |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_therm_i | input | 15 | Coarse comparator thermometer word |
| fine_therm_i | input | 67 | Fine comparator thermometer word for the selected segment |
| wr_n | input | 1 | Active-low channel select write strobe |
| chan_addr_i | input | 2 | Channel select value written while `wr_n` is low |
| pwr_dn_i | input | 1 | Power-down: holds all outputs while high |
| code_o | output | 10 | Corrected, saturated conversion code |
| ovf_o | output | 1 | Overflow flag for the sample shown on `code_o` |
| chan_o | output | 2 | Channel select that was in force for that sample |
| data_valid_o | output | 1 | Low for the first two samples after reset or wake-up |

## Verification
A channel write can land on the same edge as a power-down hold. It can also land on the edge that releases power-down. The bench issues writes inside a held stretch and on the release edge. It then expects the new select to show up on the first fresh samples, which are still marked invalid, while the held outputs stay frozen. Overflow saturation and a coarse decision that is one segment off also meet in a single sample near the top of the range, and there the expected code is computed from the ones counts alone.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   // Per-edge action of the output pipeline.
   typedef enum logic {
      PIPE_HOLD    = 1'b0,
      PIPE_ADVANCE = 1'b1
   } pipe_act_e;
endpackage

// File: rtl/tsf_therm_count.sv
// Counts the ones of a thermometer word; a bubble only shifts the count by
// the number of misplaced ones, never by a whole segment.
module tsf_therm_count #(
   parameter int W  = 15,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  therm_i,
   output logic [CW-1:0] count_o
);
   generate
      if (W < 1) begin : g_bad_width
         $error("tsf_therm_count: W must be at least 1");
      end
   endgenerate

   always_comb begin
      count_o = '0;
      for (int i = 0; i < W; i++) begin
         count_o = count_o + CW'(therm_i[i]);
      end
   end
endmodule

// File: rtl/tsf_code_correct.sv
// Merges coarse and fine counts with overlap correction and saturation.
module tsf_code_correct #(
   parameter int CCW      = 4,
   parameter int FCW      = 7,
   parameter int SEG_LSBS = 64,
   parameter int REDUN    = 2,
   parameter int CODE_W   = 10
) (
   input  logic [CCW-1:0]    coarse_cnt_i,
   input  logic [FCW-1:0]    fine_cnt_i,
   output logic [CODE_W-1:0] code_o,
   output logic              ovf_o
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;

   generate
      if (REDUN < 0 || SEG_LSBS < 2) begin : g_bad_cfg
         $error("tsf_code_correct: bad segment or overlap setting");
      end
   endgenerate

   int raw;

   always_comb begin
      raw    = int'(coarse_cnt_i) * SEG_LSBS + int'(fine_cnt_i) - REDUN;
      ovf_o  = 1'b0;
      if (raw < 0) begin
         code_o = '0;
      end else if (raw > MAX_CODE) begin
         code_o = CODE_W'(MAX_CODE);
         ovf_o  = 1'b1;
      end else begin
         code_o = CODE_W'(raw);
      end
   end
endmodule

// File: rtl/tsf_chan_latch.sv
// Channel select register, loaded by an active-low write strobe.
module tsf_chan_latch #(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] sel_o
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("tsf_chan_latch: ADDR_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o <= '0;
      end else if (!wr_n) begin
         sel_o <= addr_i;
      end
   end

   // R6: strobe high keeps the select
   p_chan_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_n |=> $stable(sel_o));

   // R6: strobe low loads the presented address
   p_chan_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> (sel_o == $past(addr_i)));
endmodule

// File: rtl/tsf_out_pipe.sv
// Fixed-latency output pipeline with power-down hold and wake-up marking.
module tsf_out_pipe
   import tsf_pkg::*;
#(
   parameter int CODE_W       = 10,
   parameter int ADDR_W       = 2,
   parameter int STAGES       = 2,
   parameter int WAKE_SAMPLES = 2,
   localparam int WCW         = $clog2(WAKE_SAMPLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              ovf_i,
   input  logic [ADDR_W-1:0] chan_i,
   output logic [CODE_W-1:0] code_o,
   output logic              ovf_o,
   output logic [ADDR_W-1:0] chan_o,
   output logic              valid_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("tsf_out_pipe: STAGES must be at least 1");
      end
      if (WAKE_SAMPLES < 1) begin : g_bad_wake
         $error("tsf_out_pipe: WAKE_SAMPLES must be at least 1");
      end
   endgenerate

   logic [CODE_W-1:0] st_code [STAGES];
   logic              st_ovf  [STAGES];
   logic [ADDR_W-1:0] st_chan [STAGES];
   logic              st_val  [STAGES];
   logic [WCW-1:0]    wake_q;
   pipe_act_e         act;

   always_comb act = pwr_dn_i ? PIPE_HOLD : PIPE_ADVANCE;

   // Wake-up counter: reloaded while powered down, counts fresh samples after.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= WCW'(WAKE_SAMPLES);
      end else if (act == PIPE_HOLD) begin
         wake_q <= WCW'(WAKE_SAMPLES);
      end else if (wake_q != '0) begin
         wake_q <= wake_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            st_code[i] <= '0;
            st_ovf[i]  <= 1'b0;
            st_chan[i] <= '0;
            st_val[i]  <= 1'b0;
         end
      end else if (act == PIPE_ADVANCE) begin
         for (int i = STAGES - 1; i > 0; i--) begin
            st_code[i] <= st_code[i-1];
            st_ovf[i]  <= st_ovf[i-1];
            st_chan[i] <= st_chan[i-1];
            st_val[i]  <= st_val[i-1];
         end
         st_code[0] <= code_i;
         st_ovf[0]  <= ovf_i;
         st_chan[0] <= chan_i;
         st_val[0]  <= (wake_q == '0);
      end
   end

   assign code_o  = st_code[STAGES-1];
   assign ovf_o   = st_ovf[STAGES-1];
   assign chan_o  = st_chan[STAGES-1];
   assign valid_o = st_val[STAGES-1];

   // R8: a power-down edge freezes every output
   p_pd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn_i |=> ($stable(code_o) && $stable(ovf_o) && $stable(chan_o) && $stable(valid_o)));

   // R9: the sample taken on the release edge is marked not valid
   p_wake_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_dn_i) |=> !st_val[0]);

   // R4: overflow always comes with a saturated code
   p_ovf_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (code_o == {CODE_W{1'b1}}));
endmodule

// File: rtl/tsf_adc_backend.sv
// Two-step flash digital back end: encode, correct, tag and pipeline.
module tsf_adc_backend #(
   parameter int COARSE_W     = 15,
   parameter int FINE_W       = 67,
   parameter int CODE_W       = 10,
   parameter int REDUN        = 2,
   parameter int ADDR_W       = 2,
   parameter int PIPE_STAGES  = 2,
   parameter int WAKE_SAMPLES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [COARSE_W-1:0] coarse_therm_i,
   input  logic [FINE_W-1:0]   fine_therm_i,
   input  logic                wr_n,
   input  logic [ADDR_W-1:0]   chan_addr_i,
   input  logic                pwr_dn_i,
   output logic [CODE_W-1:0]   code_o,
   output logic                ovf_o,
   output logic [ADDR_W-1:0]   chan_o,
   output logic                data_valid_o
);
   localparam int CCW      = $clog2(COARSE_W + 1);
   localparam int FCW      = $clog2(FINE_W + 1);
   localparam int SEG_LSBS = 1 << (CODE_W - CCW);

   generate
      if ((1 << CCW) != COARSE_W + 1) begin : g_bad_coarse
         $error("tsf_adc_backend: COARSE_W must be a power of two minus one");
      end
      if (CODE_W <= CCW) begin : g_bad_code
         $error("tsf_adc_backend: CODE_W must exceed the coarse bit count");
      end
      if (FINE_W != SEG_LSBS - 1 + 2 * REDUN) begin : g_bad_fine
         $error("tsf_adc_backend: FINE_W must equal segment thresholds plus overlap");
      end
   endgenerate

   logic [CCW-1:0]    coarse_cnt;
   logic [FCW-1:0]    fine_cnt;
   logic [CODE_W-1:0] enc_code;
   logic              enc_ovf;
   logic [ADDR_W-1:0] chan_sel;

   tsf_therm_count #(.W(COARSE_W)) u_coarse_cnt (
      .therm_i (coarse_therm_i),
      .count_o (coarse_cnt)
   );

   tsf_therm_count #(.W(FINE_W)) u_fine_cnt (
      .therm_i (fine_therm_i),
      .count_o (fine_cnt)
   );

   tsf_code_correct #(
      .CCW      (CCW),
      .FCW      (FCW),
      .SEG_LSBS (SEG_LSBS),
      .REDUN    (REDUN),
      .CODE_W   (CODE_W)
   ) u_correct (
      .coarse_cnt_i (coarse_cnt),
      .fine_cnt_i   (fine_cnt),
      .code_o       (enc_code),
      .ovf_o        (enc_ovf)
   );

   tsf_chan_latch #(.ADDR_W(ADDR_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_n   (wr_n),
      .addr_i (chan_addr_i),
      .sel_o  (chan_sel)
   );

   tsf_out_pipe #(
      .CODE_W       (CODE_W),
      .ADDR_W       (ADDR_W),
      .STAGES       (PIPE_STAGES),
      .WAKE_SAMPLES (WAKE_SAMPLES)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_dn_i (pwr_dn_i),
      .code_i   (enc_code),
      .ovf_i    (enc_ovf),
      .chan_i   (chan_sel),
      .code_o   (code_o),
      .ovf_o    (ovf_o),
      .chan_o   (chan_o),
      .valid_o  (data_valid_o)
   );

   // R3: a zero code never carries the overflow flag
   p_zero_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o == '0) |-> !ovf_o);
endmodule

// File: tb/tsf_adc_backend_bench.sv
module tsf_adc_backend_bench;
   localparam int CW = 15;
   localparam int FW = 67;
   localparam int SEG = 64;
   localparam int RED = 2;
   localparam int MAXC = 1023;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] coarse;
   logic [FW-1:0] fine;
   logic          wr_n;
   logic [1:0]    addr;
   logic          pd;
   logic [9:0]    code;
   logic          ovf;
   logic [1:0]    chan;
   logic          dval;

   always #4 clk = ~clk;

   tsf_adc_backend u_tsf_adc_backend (
      .clk(clk), .rst_n(rst_n), .coarse_therm_i(coarse), .fine_therm_i(fine),
      .wr_n(wr_n), .chan_addr_i(addr), .pwr_dn_i(pd),
      .code_o(code), .ovf_o(ovf), .chan_o(chan), .data_valid_o(dval));

   typedef struct {int code; int ovf; int chan; int val;} samp_t;

   int     checks = 0;
   int     errors = 0;
   string  phase = "R10";
   bit     done = 1'b0;
   samp_t  q[$];
   int     m_sel;
   int     m_wake;

   function automatic samp_t zero_samp();
      samp_t s;
      s.code = 0; s.ovf = 0; s.chan = 0; s.val = 0;
      return s;
   endfunction

   // Reference model, advanced on every rising edge.
   always @(posedge clk) begin
      samp_t s;
      int nc, nf, raw;
      if (!rst_n) begin
         q = '{zero_samp(), zero_samp()};
         m_sel = 0;
         m_wake = 2;
      end else begin
         if (!pd) begin
            nc = 0; nf = 0;
            for (int i = 0; i < CW; i++) nc += int'(coarse[i]);
            for (int i = 0; i < FW; i++) nf += int'(fine[i]);
            raw = nc * SEG + nf - RED;
            s.ovf  = (raw > MAXC) ? 1 : 0;
            s.code = (raw < 0) ? 0 : ((raw > MAXC) ? MAXC : raw);
            s.chan = m_sel;
            s.val  = (m_wake == 0) ? 1 : 0;
            if (m_wake > 0) m_wake--;
            q.push_back(s);
            void'(q.pop_front());
         end else begin
            m_wake = 2;
         end
         if (!wr_n) m_sel = int'(addr);
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare on every falling edge, away from the active edge.
   always @(negedge clk) begin
      if (!done && q.size() == 2) begin
         chk(phase, "code", int'(code), q[0].code);
         chk((phase == "R3") ? "R3" : "R4", "ovf", int'(ovf), q[0].ovf);
         chk((phase == "R6") ? "R6" : "R7", "chan", int'(chan), q[0].chan);
         chk((phase == "R8") ? "R8" : "R9", "valid", int'(dval), q[0].val);
      end
   end

   function automatic logic [FW-1:0] therm(int n, bit bub);
      logic [FW-1:0] w = '0;
      for (int i = 0; i < FW; i++) if (i < n) w[i] = 1'b1;
      if (bub && n >= 1 && n < FW) begin
         w[n-1] = 1'b0;
         w[n]   = 1'b1;
      end
      return w;
   endfunction

   task automatic put_words(int nc, int nf, bit bc, bit bf);
      logic [FW-1:0] cw;
      @(negedge clk);
      cw = therm(nc, bc);
      coarse = cw[CW-1:0];
      fine = therm(nf, bf);
   endtask

   // Ideal comparator banks for an input expressed in LSB steps.
   task automatic put_level(int lvl, bit bc, bit bf);
      int nc = 0;
      int nf;
      for (int k = 1; k <= CW; k++) if (lvl >= SEG * k) nc++;
      nf = lvl - SEG * nc + RED;
      if (nf < 0) nf = 0;
      if (nf > FW) nf = FW;
      put_words(nc, nf, bc, bf);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: run did not end");
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; pd = 1'b0; wr_n = 1'b1; addr = 2'd0;
      coarse = '0; fine = '0;
      // R10: reset values
      repeat (3) @(negedge clk);
      chk("R10", "reset code", int'(code), 0);
      chk("R10", "reset valid", int'(dval), 0);
      chk("R10", "reset chan/ovf", int'(chan) + int'(ovf), 0);
      rst_n = 1'b1;

      phase = "R1";
      for (int l = 0; l < 1024; l += 37) put_level(l, 1'b0, 1'b0);
      put_level(63, 0, 0); put_level(64, 0, 0); put_level(127, 0, 0);
      put_level(128, 0, 0); put_level(959, 0, 0); put_level(960, 0, 0);
      // R1: coarse decision one segment off, corrected by the overlap
      put_words(1, 67, 0, 0); put_words(2, 1, 0, 0); put_words(2, 0, 0, 0);
      put_words(14, 67, 0, 0); put_words(3, 66, 0, 0);

      phase = "R5";
      for (int i = 0; i < 6; i++) put_level((i % 2 == 0) ? 5 : 900, 0, 0);

      phase = "R2";
      put_level(300, 1'b0, 1'b1); put_level(300, 1'b1, 1'b0);
      put_level(700, 1'b1, 1'b1); put_level(65, 1'b0, 1'b1);

      phase = "R3";
      put_level(-1, 0, 0); put_level(-2, 0, 0); put_level(-40, 0, 0);
      put_words(0, 1, 0, 0); put_level(0, 0, 0);

      phase = "R4";
      for (int l = 1021; l <= 1030; l++) put_level(l, 0, 0);
      put_words(15, 67, 0, 0); put_words(14, 67, 0, 0);

      phase = "R6";
      for (int c = 0; c < 4; c++) begin
         put_level(100 * c + 10, 0, 0);
         wr_n = 1'b0; addr = 2'(c);
         put_level(100 * c + 20, 0, 0);
         wr_n = 1'b1; addr = 2'(3 - c);
         put_level(100 * c + 30, 0, 0);
         put_level(100 * c + 40, 0, 0);
      end
      phase = "R7";
      wr_n = 1'b0; addr = 2'd2;
      put_level(500, 0, 0);
      addr = 2'd1;
      put_level(510, 0, 0);
      wr_n = 1'b1;
      put_level(520, 0, 0); put_level(530, 0, 0); put_level(540, 0, 0);

      phase = "R8";
      pd = 1'b1;
      put_level(10, 0, 0);
      wr_n = 1'b0; addr = 2'd3;
      put_level(1000, 0, 0);
      wr_n = 1'b1;
      put_level(1030, 0, 0); put_level(-5, 0, 0);
      phase = "R9";
      pd = 1'b0;
      wr_n = 1'b0; addr = 2'd0;
      put_level(200, 0, 0);
      wr_n = 1'b1;
      for (int i = 0; i < 5; i++) put_level(210 + i, 0, 0);
      pd = 1'b1;
      put_level(333, 0, 0);
      pd = 1'b0;
      for (int i = 0; i < 5; i++) put_level(400 + 3 * i, 0, 0);

      phase = "R5";
      repeat (3) put_level(777, 0, 0);
      @(negedge clk);
      done = 1'b1;
      report();
      $finish;
   end
endmodule